// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the address field of an instruction into either an effective memory address or a ready operand value. A 4-bit mode code picks one of nine ways to form the result. Some modes pass the field through unchanged. Some add the field to the index register, the base register or the next-instruction program counter. Some return register R. One fetches a pointer word from memory. The consumer raises `start` for one cycle with all operands valid. It then waits for `done`, and in that cycle it reads `result` together with `isValue`, which tells it whether the result is a value or an address.

The pointer fetch for the indirect mode runs over a byte-wide read handshake. The unit holds `memReq` and `memAddr` steady until `memAck` arrives, and `memData` must be valid in that same cycle. A 16-bit word takes two reads. The lower address supplies the low byte and is read first. Every other mode completes in one cycle and never touches memory.

Mode codes: 0 direct, 1 indirect, 2 register-direct, 3 register-indirect, 4 immediate, 5 implicit, 6 relative, 7 indexed, 8 base. Codes 9 to 15 are unused.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (direct): in the cycle after `start`, `done` is 1, `result` equals the field and `isValue` is 0.
- R2: Mode 1 (indirect): the unit reads address field first and then field+1 (mod 2^16). The first byte becomes `result[7:0]`, the second becomes `result[15:8]`, and `isValue` is 0.
- R3: In mode 1, `done` rises in the cycle after the second `memAck`. While `memReq` is high without `memAck`, `memReq` and `memAddr` hold their values into the next cycle.
- R4: Mode 2 (register-direct): `result` equals register R and `isValue` is 1. `done` comes in the cycle after `start`.
- R5: Mode 3 (register-indirect): `result` equals register R and `isValue` is 0. `done` comes in the cycle after `start`.
- R6: Mode 4 (immediate): `result` equals the field and `isValue` is 1. `done` comes in the cycle after `start`.
- R7: Mode 5 (implicit) and codes 9 to 15 raise no `memReq`. `done` comes in the cycle after `start`, with `result` 0 and `isValue` 0.
- R8: Mode 6 (relative): `result` equals the next-instruction PC plus field[7:0] taken as a signed 8-bit value, wrapping mod 2^16. Field bits 15:8 have no effect.
- R9: Mode 7 (indexed): `result` equals field plus X, mod 2^16, with `isValue` 0.
- R10: Mode 8 (base): `result` equals the base register plus field, mod 2^16, with `isValue` 0.
- R11: A `start` raised while an indirect fetch is in progress is ignored. Each accepted `start` produces exactly one single-cycle `done` pulse.
- R12: During and right after reset, `done`, `memReq`, `result` and `isValue` are all 0.
- R13: Operands are sampled only in the `start` cycle. Changing them afterwards does not alter the result of an indirect fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing mode code |
| field | input | 16 | Instruction address/offset/value field |
| nextPc | input | 16 | Address of the following instruction |
| idxX | input | 16 | Index register |
| baseReg | input | 16 | Base register |
| regR | input | 16 | Register R |
| memReq | output | 1 | Byte read request |
| memAddr | output | 16 | Byte read address |
| memAck | input | 1 | Read acknowledge, data valid |
| memData | input | 8 | Read data byte |
| result | output | 16 | Effective address or operand value |
| isValue | output | 1 | 1 when result is an operand value |
| done | output | 1 | Result valid pulse |

## Verification
A wrong byte counter or pointer shows up on `memAddr` on the very next read. The result then has its bytes swapped or taken from the wrong address, and a lost acknowledge leaves `done` missing after the second reply. A control state machine stuck busy makes single-cycle modes answer late or not at all. A stray accepted `start` shows as a second `done` pulse. Mis-decoded modes or sign handling appear on `result` one cycle after `start`, so each bad operation is caught at its own `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;
  localparam int IDX_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_DIRECT   = 4'd0,
    MD_INDIRECT = 4'd1,
    MD_REGDIR   = 4'd2,
    MD_REGIND   = 4'd3,
    MD_IMM      = 4'd4,
    MD_IMPLICIT = 4'd5,
    MD_REL      = 4'd6,
    MD_INDEX    = 4'd7,
    MD_BASE     = 4'd8
  } mode_e;

  typedef struct packed {
    logic             capture;  // latch single-cycle result
    logic             ldPtr;    // latch pointer, clear result
    logic             wrByte;   // store returned byte
    logic [IDX_W-1:0] byteIdx;  // byte slot being read
  } strobe_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              memAck,
  output strobe_t           strb,
  output logic              memReq,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  typedef enum logic {ST_IDLE, ST_READ} st_e;
  st_e              stQ;
  logic [IDX_W-1:0] cntQ;
  logic             isInd;
  logic             lastByte;

  assign isInd    = (mode == MODE_W'(MD_INDIRECT));
  assign lastByte = (cntQ == LAST);

  always_comb begin
    strb.capture = (stQ == ST_IDLE) && start && !isInd;
    strb.ldPtr   = (stQ == ST_IDLE) && start && isInd;
    strb.wrByte  = (stQ == ST_READ) && memAck;
    strb.byteIdx = cntQ;
    memReq       = (stQ == ST_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      cntQ <= '0;
      done <= 1'b0;
    end else begin
      done <= strb.capture || (strb.wrByte && lastByte);
      case (stQ)
        ST_IDLE: if (strb.ldPtr) begin
          stQ  <= ST_READ;
          cntQ <= '0;
        end
        ST_READ: if (memAck) begin
          if (lastByte) stQ <= ST_IDLE;
          else          cntQ <= cntQ + 1'b1;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);  // R3
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !done);  // R11
endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int OW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     nextPc,
  input  logic [AW-1:0]     idxX,
  input  logic [AW-1:0]     baseReg,
  input  logic [AW-1:0]     regR,
  input  logic [BW-1:0]     memData,
  output logic [AW-1:0]     memAddr,
  output logic [AW-1:0]     result,
  output logic              isValue
);
  localparam int EXT_W = AW - OW;

  logic [AW-1:0] ptrQ;
  logic [AW-1:0] fastRes;
  logic          fastVal;
  logic [AW-1:0] relOff;
  mode_e         modeE;

  assign modeE   = mode_e'(mode);
  assign relOff  = {{EXT_W{field[OW-1]}}, field[OW-1:0]};
  assign memAddr = ptrQ + AW'(strb.byteIdx);

  always_comb begin
    fastRes = '0;
    fastVal = 1'b0;
    case (modeE)
      MD_DIRECT: fastRes = field;
      MD_REGDIR: begin fastRes = regR;  fastVal = 1'b1; end
      MD_REGIND: fastRes = regR;
      MD_IMM:    begin fastRes = field; fastVal = 1'b1; end
      MD_REL:    fastRes = nextPc + relOff;
      MD_INDEX:  fastRes = field + idxX;
      MD_BASE:   fastRes = baseReg + field;
      default:   fastRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ    <= '0;
      result  <= '0;
      isValue <= 1'b0;
    end else if (strb.capture) begin
      result  <= fastRes;
      isValue <= fastVal;
    end else if (strb.ldPtr) begin
      ptrQ    <= field;
      result  <= '0;
      isValue <= 1'b0;
    end else if (strb.wrByte) begin
      result[strb.byteIdx*BW +: BW] <= memData;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> $stable(ptrQ));  // R13
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int OW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     nextPc,
  input  logic [AW-1:0]     idxX,
  input  logic [AW-1:0]     baseReg,
  input  logic [AW-1:0]     regR,
  output logic              memReq,
  output logic [AW-1:0]     memAddr,
  input  logic              memAck,
  input  logic [BW-1:0]     memData,
  output logic [AW-1:0]     result,
  output logic              isValue,
  output logic              done
);
  localparam int NBYTES = AW / BW;

  strobe_t strb;

  ea_ctrl #(.NBYTES(NBYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .memAck(memAck),
    .strb(strb), .memReq(memReq), .done(done)
  );

  ea_dpath #(.AW(AW), .BW(BW), .OW(OW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .field(field),
    .nextPc(nextPc), .idxX(idxX), .baseReg(baseReg), .regR(regR),
    .memData(memData), .memAddr(memAddr), .result(result), .isValue(isValue)
  );

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    done && $past(start) && !$past(memReq) && $past(mode) == MODE_W'(MD_DIRECT)
    |-> result == $past(field) && !isValue);  // R1
  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> memAddr == $past(field));  // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));  // R3
  AST_IMPLICIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    start && !memReq && mode == MODE_W'(MD_IMPLICIT)
    |=> done && !memReq && result == '0);  // R7
endmodule

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] field = '0, nextPc = '0, idxX = '0, baseReg = '0, regR = '0;
  logic        memReq, memAck = 1'b0;
  logic [15:0] memAddr, result;
  logic [7:0]  memData = '0;
  logic        isValue, done;

  int checks = 0, fails = 0, cyc = 0;
  int logN = 0, lastAckCyc = 0, delayCnt = 0, waitCnt = 0;
  logic [15:0] addrLog [0:1023];
  logic [31:0] lfsr = 32'hACE1_2468;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  ea_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .field(field),
    .nextPc(nextPc), .idxX(idxX), .baseReg(baseReg), .regR(regR),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .result(result), .isValue(isValue), .done(done)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // byte-wide memory with a rotating reply delay of 0..3 cycles
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt == 0) begin
        memAck = 1'b1;
        memData = memByte(memAddr);
        if (logN < 1024) addrLog[logN] = memAddr;
        logN++;
        lastAckCyc = cyc;
        delayCnt = (delayCnt + 1) % 4;
        waitCnt = delayCnt;
      end else waitCnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd0: return "R1"; 4'd1: return "R2"; 4'd2: return "R4"; 4'd3: return "R5";
      4'd4: return "R6"; 4'd6: return "R8"; 4'd7: return "R9"; 4'd8: return "R10";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [16:0] expOf(input logic [3:0] m, input logic [15:0] f,
      input logic [15:0] pc, input logic [15:0] x, input logic [15:0] b,
      input logic [15:0] r);
    case (m)
      4'd0: return {1'b0, f};
      4'd1: return {1'b0, memByte(f + 16'd1), memByte(f)};
      4'd2: return {1'b1, r};
      4'd3: return {1'b0, r};
      4'd4: return {1'b1, f};
      4'd6: return {1'b0, pc + {{8{f[7]}}, f[7:0]}};
      4'd7: return {1'b0, f + x};
      4'd8: return {1'b0, b + f};
      default: return 17'd0;
    endcase
  endfunction

  task automatic doOp(input logic [3:0] m, input logic [15:0] f, input logic [15:0] pc,
                      input logic [15:0] x, input logic [15:0] b, input logic [15:0] r,
                      input bit disturb);
    int n = 1;
    int logStart;
    logic [16:0] e;
    e = expOf(m, f, pc, x, b, r);
    start = 1'b1; mode = m; field = f; nextPc = pc; idxX = x; baseReg = b; regR = r;
    logStart = logN;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin  // R11 / R13: busy start with other operands
      start = 1'b1; mode = 4'd0; field = ~f; regR = ~r;
    end
    if (!done) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      while (!done && n < 60) begin @(negedge clk); n++; end
    end
    start = 1'b0;
    chk(done, "R11 done seen", 32'(done), 1);
    chk(result == e[15:0], reqOf(m), 32'(result), 32'(e[15:0]));
    chk(isValue == e[16], {reqOf(m), " isValue"}, 32'(isValue), 32'(e[16]));
    if (m == 4'd1) begin
      chk(logN - logStart == 2, "R2 read count", 32'(logN - logStart), 2);
      chk(addrLog[logStart] == f, "R2 low address first", 32'(addrLog[logStart]), 32'(f));
      chk(addrLog[logStart + 1] == f + 16'd1, "R2 high address", 32'(addrLog[logStart + 1]),
          32'(f + 16'd1));
      chk(cyc == lastAckCyc + 1, "R3 done after last ack", 32'(cyc), 32'(lastAckCyc + 1));
    end else begin
      chk(n == 1, {reqOf(m), " one-cycle latency"}, 32'(n), 1);
      chk(logN == logStart, "R7 no memory read", 32'(logN - logStart), 0);
    end
    @(negedge clk);
    chk(!done, "R11 single done pulse", 32'(done), 0);
    chk(!memReq, "R11 idle after done", 32'(memReq), 0);
  endtask

  function automatic logic [15:0] rnd16();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[15:0] ^ lfsr[31:16];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !memReq, "R12 reset outputs", {30'd0, done, memReq}, 0);
    chk(result == 0 && !isValue, "R12 reset result", 32'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memReq && result == 0, "R12 after reset", 32'(result), 0);

    // documented examples and edges
    doOp(4'd6, 16'h003C, 16'hF002, 0, 0, 0, 0);       // R8 -> F03E
    doOp(4'd6, 16'h0005, 16'h0002, 0, 0, 0, 0);       // R8 -> 7
    doOp(4'd6, 16'hAB80, 16'h0010, 0, 0, 0, 0);       // R8 negative, high byte ignored
    doOp(4'd6, 16'h00FF, 16'h0000, 0, 0, 0, 0);       // R8 wrap below zero
    doOp(4'd7, 16'h102A, 16'h0, 16'h2005, 0, 0, 0);   // R9 -> 302F
    doOp(4'd7, 16'hFFFF, 16'h0, 16'h0001, 0, 0, 0);   // R9 wrap
    doOp(4'd8, 16'h2005, 16'h0, 0, 16'h102A, 0, 0);   // R10 -> 302F
    doOp(4'd1, 16'hFFFF, 0, 0, 0, 0, 0);              // R2 pointer wraps
    doOp(4'd1, 16'h1234, 0, 0, 0, 16'h5555, 1);       // R11 R13 disturbed

    // sweep every mode code
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 12; k++)
        doOp(4'(m), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), (k % 3) == 0);

    // back-to-back: start in the cycle done is high
    start = 1'b1; mode = 4'd4; field = 16'h0A0A;
    @(negedge clk);
    field = 16'h0B0B;
    @(negedge clk);
    start = 1'b0;
    chk(done && result == 16'h0B0B, "R6 back-to-back", 32'(result), 32'h0B0B);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule